// File: doc/BRIEF.md
# Real-Time Counter with Sticky Interrupt Flags

This block is a 32-bit real-time counter for a slow timebase. A single-cycle `tick_i` pulse, already brought into the system clock domain, marks each rising edge of the counter clock, and the count advances by one on every such pulse. When the count reaches the programmed period it wraps back to zero. Two events are watched: the count equalling the compare value, and the wrap. Each event latches a sticky flag one tick after it happens.

Software reaches the block through a byte-wide register port. The port holds a control byte with a 2-bit priority level for each source, a flag byte, and three 32-bit values (count, compare, period), each split into four byte addresses with the least significant byte first. Multi-byte accesses are made coherent by two temporary registers. Reading the lowest count byte captures the upper three bytes for the reads that follow. Writes to the lower bytes of a 32-bit value are held in a buffer and reach the target only when the top byte is written.

For each source the block drives a 2-bit request level to an external interrupt controller. It takes back a one-cycle acknowledge when that source's vector is taken, and the acknowledge clears the flag.

Top module: `rtc_counter_top`

## Requirements
- R1: The count increases by exactly one on each cycle where `tick_i` is high, and holds its value on all other cycles unless a committed count write loads it.
- R2: On a tick where the count equals the period, the count becomes zero. The period resets to 0xFFFFFFFF, so with the reset period the count wraps from 0xFFFFFFFF to 0.
- R3: The compare flag is bit 1 of the flag byte at address 1. It sets on the first tick after a tick on which the count equalled the compare value.
- R4: The overflow flag is bit 0 of the flag byte. It sets on the first tick after a tick on which the count wrapped.
- R5: Writing the flag byte clears every flag whose bit is written as one and leaves flags written as zero unchanged. If a set and a write-one clear of the same flag fall in the same cycle, the flag ends up set.
- R6: A high `ack_cmp_i` clears the compare flag and a high `ack_ovf_i` clears the overflow flag, unless a set of that flag happens in the same cycle.
- R7: The control byte at address 0 holds the compare level in bits 3:2 and the overflow level in bits 1:0. Bits 7:4 of the control byte and bits 7:2 of the flag byte always read as zero.
- R8: Each request output equals its source's level field while that source's flag is set, and is zero otherwise. A zero level therefore disables the request.
- R9: The count occupies addresses 2 to 5, least significant byte first. A read of address 2 returns the live low byte and captures count bits 31:8. Reads of addresses 3 to 5 return the captured bytes.
- R10: Compare (addresses 6 to 9) and period (addresses 10 to 13) read back their committed values. A write to any of the three lower bytes of count, compare or period goes into one shared three-byte buffer. A write to the top byte (address 5, 9 or 13) loads the target with the written byte above the buffered bytes. A count load takes precedence over a tick in the same cycle.
- R11: After reset the control byte, the flags, the count and the compare value are zero, and the period is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per counter clock rising edge |
| addr_i | input | 4 | Register byte address |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rd_en_i | input | 1 | Register read strobe; only triggers the count capture |
| rdata_o | output | 8 | Register read data for `addr_i` (combinational) |
| ack_cmp_i | input | 1 | Compare vector taken |
| ack_ovf_i | input | 1 | Overflow vector taken |
| irq_cmp_lvl_o | output | 2 | Compare request level, zero when idle |
| irq_ovf_lvl_o | output | 2 | Overflow request level, zero when idle |

## Verification
Several properties are checked on every cycle. The count holds without a tick, steps by one on a tick, and returns to zero at the period. Flags only rise on a tick edge, and an acknowledge without a tick clears its flag. The padding bits of the control byte read as zero, and a zero level keeps the request silent. The bench's scenarios are needed for everything else: the one-tick delay between a condition and its flag, the set-beats-clear collision, the coherence of a count captured across four byte reads, the commit-on-top-byte behaviour of the shared write buffer, and the full 32-bit wrap from the reset period. The bench checks these against a reference model driven by random and directed register traffic.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int BYTE_W    = 8;
    localparam int CNT_BYTES = 4;
    localparam int CNT_W     = BYTE_W * CNT_BYTES;
    localparam int BUF_W     = CNT_W - BYTE_W;
    localparam int LVL_W     = 2;
    localparam int NSRC      = 2;
    localparam int SRC_OVF   = 0;
    localparam int SRC_CMP   = 1;
    localparam int CTRL_W    = LVL_W * NSRC;
    localparam int ADDR_W    = 4;
    localparam int A_CTRL    = 0;
    localparam int A_FLAGS   = 1;
    localparam int A_CNT     = 2;
    localparam int A_CMP     = A_CNT + CNT_BYTES;
    localparam int A_PER     = A_CMP + CNT_BYTES;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [CNT_W-1:0]  cmp;
        logic [CNT_W-1:0]  per;
        logic [BUF_W-1:0]  wbuf;
        logic [BUF_W-1:0]  rlatch;
    } host_regs_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [NSRC-1:0]  pend;
    } core_state_t;
endpackage

// File: rtl/rtc_count_core.sv
module rtc_count_core
    import rtc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 load_i,
    input  logic [CNT_W-1:0]     load_val_i,
    input  logic [CNT_W-1:0]     cmp_i,
    input  logic [CNT_W-1:0]     per_i,
    output logic [CNT_W-1:0]     cnt_o,
    output logic [NSRC-1:0]      evt_o
);
    core_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        evt_o = '0;
        if (tick_i) begin
            // Conditions seen on this tick surface as events on the next tick.
            evt_o              = st_q.pend;
            st_d.pend[SRC_CMP] = (st_q.cnt == cmp_i);
            st_d.pend[SRC_OVF] = (st_q.cnt == per_i);
            st_d.cnt           = (st_q.cnt == per_i) ? '0 : st_q.cnt + CNT_W'(1);
        end
        if (load_i) begin
            st_d.cnt = load_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/rtc_irq_src.sv
module rtc_irq_src
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic             wclr_i,
    input  logic             ack_i,
    input  logic [LVL_W-1:0] lvl_i,
    output logic             flag_o,
    output logic [LVL_W-1:0] req_lvl_o
);
    logic flag_d, flag_q;

    always_comb begin
        // A set in the same cycle overrides either form of clear.
        flag_d = set_i | (flag_q & ~wclr_i & ~ack_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o    = flag_q;
    assign req_lvl_o = flag_q ? lvl_i : '0;
endmodule

// File: rtl/rtc_counter_top.sv
module rtc_counter_top
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              rd_en_i,
    output logic [BYTE_W-1:0] rdata_o,
    input  logic              ack_cmp_i,
    input  logic              ack_ovf_i,
    output logic [LVL_W-1:0]  irq_cmp_lvl_o,
    output logic [LVL_W-1:0]  irq_ovf_lvl_o
);
    host_regs_t        regs_d, regs_q;
    logic              cnt_load_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [CNT_W-1:0]  per_w;
    logic [CNT_W-1:0]  commit_val_w;
    logic [NSRC-1:0]   evt_w;
    logic [NSRC-1:0]   flag_w;
    logic [NSRC-1:0]   wclr_w;
    logic [NSRC-1:0]   ack_w;
    logic [LVL_W-1:0]  req_w [NSRC];

    assign commit_val_w = {wdata_i, regs_q.wbuf};
    assign per_w        = regs_q.per;

    always_comb begin
        regs_d     = regs_q;
        cnt_load_w = 1'b0;
        wclr_w     = '0;
        if (wr_en_i) begin
            if (addr_i == ADDR_W'(A_CTRL)) begin
                regs_d.ctrl = wdata_i[CTRL_W-1:0];
            end
            if (addr_i == ADDR_W'(A_FLAGS)) begin
                wclr_w = wdata_i[NSRC-1:0];
            end
            for (int b = 0; b < CNT_BYTES - 1; b++) begin
                if (addr_i == ADDR_W'(A_CNT + b) ||
                    addr_i == ADDR_W'(A_CMP + b) ||
                    addr_i == ADDR_W'(A_PER + b)) begin
                    regs_d.wbuf[b*BYTE_W +: BYTE_W] = wdata_i;
                end
            end
            if (addr_i == ADDR_W'(A_CNT + CNT_BYTES - 1)) begin
                cnt_load_w = 1'b1;
            end
            if (addr_i == ADDR_W'(A_CMP + CNT_BYTES - 1)) begin
                regs_d.cmp = commit_val_w;
            end
            if (addr_i == ADDR_W'(A_PER + CNT_BYTES - 1)) begin
                regs_d.per = commit_val_w;
            end
        end
        if (rd_en_i && addr_i == ADDR_W'(A_CNT)) begin
            regs_d.rlatch = cnt_w[CNT_W-1:BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q      <= '0;
            regs_q.per  <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(A_CTRL)) begin
            rdata_o = BYTE_W'(regs_q.ctrl);
        end
        if (addr_i == ADDR_W'(A_FLAGS)) begin
            rdata_o = BYTE_W'(flag_w);
        end
        if (addr_i == ADDR_W'(A_CNT)) begin
            rdata_o = cnt_w[BYTE_W-1:0];
        end
        for (int b = 1; b < CNT_BYTES; b++) begin
            if (addr_i == ADDR_W'(A_CNT + b)) begin
                rdata_o = regs_q.rlatch[(b-1)*BYTE_W +: BYTE_W];
            end
        end
        for (int b = 0; b < CNT_BYTES; b++) begin
            if (addr_i == ADDR_W'(A_CMP + b)) begin
                rdata_o = regs_q.cmp[b*BYTE_W +: BYTE_W];
            end
            if (addr_i == ADDR_W'(A_PER + b)) begin
                rdata_o = regs_q.per[b*BYTE_W +: BYTE_W];
            end
        end
    end

    rtc_count_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .load_i     (cnt_load_w),
        .load_val_i (commit_val_w),
        .cmp_i      (regs_q.cmp),
        .per_i      (regs_q.per),
        .cnt_o      (cnt_w),
        .evt_o      (evt_w)
    );

    assign ack_w[SRC_OVF] = ack_ovf_i;
    assign ack_w[SRC_CMP] = ack_cmp_i;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        rtc_irq_src u_src (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (evt_w[s]),
            .wclr_i    (wclr_w[s]),
            .ack_i     (ack_w[s]),
            .lvl_i     (regs_q.ctrl[s*LVL_W +: LVL_W]),
            .flag_o    (flag_w[s]),
            .req_lvl_o (req_w[s])
        );
    end

    assign irq_ovf_lvl_o = req_w[SRC_OVF];
    assign irq_cmp_lvl_o = req_w[SRC_CMP];
endmodule

// File: rtl/rtc_counter_chk.sv
module rtc_counter_chk
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [BYTE_W-1:0] rdata_o,
    input logic              ack_cmp_i,
    input logic              ack_ovf_i,
    input logic [LVL_W-1:0]  irq_cmp_lvl_o,
    input logic [LVL_W-1:0]  irq_ovf_lvl_o,
    input logic              cnt_load_w,
    input logic [CNT_W-1:0]  cnt_w,
    input logic [CNT_W-1:0]  per_w,
    input logic [NSRC-1:0]   flag_w
);
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cnt_load_w) |=> $stable(cnt_w));

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cnt_load_w && cnt_w != per_w) |=> (cnt_w == $past(cnt_w) + CNT_W'(1)));

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cnt_load_w && cnt_w == per_w) |=> (cnt_w == '0));

    p_cmp_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_w[SRC_CMP]) |-> $past(tick_i));

    p_ovf_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_w[SRC_OVF]) |-> $past(tick_i));

    p_ack_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_cmp_i && !tick_i) |=> !flag_w[SRC_CMP]);

    p_ack_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ovf_i && !tick_i) |=> !flag_w[SRC_OVF]);

    p_ctrl_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_W'(A_CTRL)) |-> (rdata_o[BYTE_W-1:LVL_W*NSRC] == '0));

    p_idle_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_w[SRC_CMP] |-> irq_cmp_lvl_o == '0) and (!flag_w[SRC_OVF] |-> irq_ovf_lvl_o == '0));
endmodule

bind rtc_counter_top rtc_counter_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .addr_i        (addr_i),
    .rdata_o       (rdata_o),
    .ack_cmp_i     (ack_cmp_i),
    .ack_ovf_i     (ack_ovf_i),
    .irq_cmp_lvl_o (irq_cmp_lvl_o),
    .irq_ovf_lvl_o (irq_ovf_lvl_o),
    .cnt_load_w    (cnt_load_w),
    .cnt_w         (cnt_w),
    .per_w         (per_w),
    .flag_w        (flag_w)
);

// File: tb/rtc_counter_top_tb_top.sv
`timescale 1ns/1ps
module rtc_counter_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [3:0] addr_i = '0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic       rd_en_i = 1'b0;
    logic [7:0] rdata_o;
    logic       ack_cmp_i = 1'b0;
    logic       ack_ovf_i = 1'b0;
    logic [1:0] irq_cmp_lvl_o;
    logic [1:0] irq_ovf_lvl_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_counter_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i),
        .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o),
        .ack_cmp_i(ack_cmp_i), .ack_ovf_i(ack_ovf_i),
        .irq_cmp_lvl_o(irq_cmp_lvl_o), .irq_ovf_lvl_o(irq_ovf_lvl_o)
    );

    // Reference model state
    logic [31:0] m_cnt, m_cmp, m_per;
    logic [23:0] m_buf, m_lat;
    logic [3:0]  m_ctrl;
    logic        m_pc, m_po, m_fc, m_fo;

    task automatic m_reset();
        m_cnt = '0; m_cmp = '0; m_per = '1; m_buf = '0; m_lat = '0;
        m_ctrl = '0; m_pc = 0; m_po = 0; m_fc = 0; m_fo = 0;
    endtask

    function automatic logic [7:0] m_read(input logic [3:0] a);
        case (a)
            4'd0:  return {4'h0, m_ctrl};
            4'd1:  return {6'h0, m_fc, m_fo};
            4'd2:  return m_cnt[7:0];
            4'd3:  return m_lat[7:0];
            4'd4:  return m_lat[15:8];
            4'd5:  return m_lat[23:16];
            4'd6:  return m_cmp[7:0];
            4'd7:  return m_cmp[15:8];
            4'd8:  return m_cmp[23:16];
            4'd9:  return m_cmp[31:24];
            4'd10: return m_per[7:0];
            4'd11: return m_per[15:8];
            4'd12: return m_per[23:16];
            4'd13: return m_per[31:24];
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One system clock cycle: drive at negedge, check before posedge, update model after.
    task automatic step(input bit tk, input bit wr, input bit rd, input logic [3:0] a,
                        input logic [7:0] d, input bit akc, input bit ako, input string tag);
        logic [31:0] n_cnt;
        logic [23:0] n_buf, n_lat;
        logic [3:0]  n_ctrl;
        logic [31:0] n_cmp, n_per;
        logic        n_pc, n_po, setc, seto;
        @(negedge clk);
        tick_i = tk; wr_en_i = wr; rd_en_i = rd; addr_i = a; wdata_i = d;
        ack_cmp_i = akc; ack_ovf_i = ako;
        #1;
        if (rd) chk(tag, {24'h0, rdata_o}, {24'h0, m_read(a)});
        chk("R8 cmp level", {30'h0, irq_cmp_lvl_o}, {30'h0, m_fc ? m_ctrl[3:2] : 2'b00});
        chk("R8 ovf level", {30'h0, irq_ovf_lvl_o}, {30'h0, m_fo ? m_ctrl[1:0] : 2'b00});
        n_cnt = m_cnt; n_buf = m_buf; n_lat = m_lat; n_ctrl = m_ctrl;
        n_cmp = m_cmp; n_per = m_per; n_pc = m_pc; n_po = m_po; setc = 0; seto = 0;
        if (tk) begin
            setc = m_pc; seto = m_po;
            n_pc = (m_cnt == m_cmp);
            n_po = (m_cnt == m_per);
            n_cnt = (m_cnt == m_per) ? 32'h0 : m_cnt + 1;
        end
        if (wr) begin
            case (a)
                4'd0: n_ctrl = d[3:0];
                4'd2, 4'd6, 4'd10: n_buf[7:0] = d;
                4'd3, 4'd7, 4'd11: n_buf[15:8] = d;
                4'd4, 4'd8, 4'd12: n_buf[23:16] = d;
                4'd5:  n_cnt = {d, m_buf};
                4'd9:  n_cmp = {d, m_buf};
                4'd13: n_per = {d, m_buf};
                default: ;
            endcase
        end
        if (rd && a == 4'd2) n_lat = m_cnt[31:8];
        @(posedge clk);
        m_fc = setc | (m_fc & !(wr && a == 4'd1 && d[1]) & !akc);
        m_fo = seto | (m_fo & !(wr && a == 4'd1 && d[0]) & !ako);
        m_cnt = n_cnt; m_buf = n_buf; m_lat = n_lat; m_ctrl = n_ctrl;
        m_cmp = n_cmp; m_per = n_per; m_pc = n_pc; m_po = n_po;
    endtask

    task automatic idle(); step(0, 0, 0, 4'd15, 8'h00, 0, 0, ""); endtask
    task automatic tick(); step(1, 0, 0, 4'd15, 8'h00, 0, 0, ""); endtask
    task automatic wr(input logic [3:0] a, input logic [7:0] d); step(0, 1, 0, a, d, 0, 0, ""); endtask
    task automatic rd(input logic [3:0] a, input string tag); step(0, 0, 1, a, 8'h00, 0, 0, tag); endtask

    task automatic wr32(input logic [3:0] base, input logic [31:0] v);
        for (int b = 0; b < 4; b++) wr(base + 4'(b), v[b*8 +: 8]);
    endtask

    task automatic rd_all(input string tag);
        for (int a = 0; a < 14; a++) rd(4'(a), tag);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R11 reset values
        rd_all("R11 reset value");

        // R2: full 32-bit wrap using reset period
        wr32(4'd2, 32'hFFFF_FFFE);
        rd(4'd2, "R10 count load");
        tick(); tick();
        rd(4'd2, "R2 wrap low byte"); rd(4'd5, "R2 wrap high byte");
        rd(4'd1, "R4 no flag before next tick");
        tick();
        rd(4'd1, "R4 overflow flag after next tick");

        // R7 control padding and levels
        wr(4'd0, 8'hFB);
        rd(4'd0, "R7 ctrl upper bits zero");
        wr(4'd1, 8'h03);
        rd(4'd1, "R5 write-one clear");

        // R3: compare at 7, period 20
        wr32(4'd10, 32'd20);
        wr32(4'd6, 32'd7);
        wr32(4'd2, 32'd5);
        tick(); tick(); // count 5->6->7
        rd(4'd1, "R3 not yet");
        tick();         // condition tick at 7
        rd(4'd1, "R3 flag not on condition tick");
        tick();
        rd(4'd1, "R3 flag on following tick");
        // R6 ack clears
        step(0, 0, 1, 4'd1, 8'h00, 1, 0, "R6 before ack");
        rd(4'd1, "R6 ack cleared");

        // R5: set beats write-one clear; overflow at period 20
        wr32(4'd2, 32'd20);
        tick();                           // wrap condition
        step(1, 1, 0, 4'd1, 8'h01, 0, 0, ""); // set and clear together
        rd(4'd1, "R5 set wins");
        wr(4'd1, 8'h00);
        rd(4'd1, "R5 write zero keeps flag");
        step(1, 0, 0, 4'd15, 8'h00, 0, 1, ""); // ack during tick with no pending set
        rd(4'd1, "R6 ack with tick");

        // R9 coherent count read
        wr32(4'd2, 32'h1234_56F0);
        wr32(4'd10, 32'hFFFF_FFFF);
        rd(4'd2, "R9 low byte");
        tick(); tick();
        rd(4'd3, "R9 latched byte1"); rd(4'd4, "R9 latched byte2"); rd(4'd5, "R9 latched byte3");

        // R10 partial write does not take effect
        wr(4'd6, 8'hAA); wr(4'd7, 8'hBB);
        rd(4'd6, "R10 compare unchanged before top byte");
        wr(4'd8, 8'hCC); wr(4'd9, 8'hDD);
        rd(4'd6, "R10 compare committed"); rd(4'd9, "R10 compare top");
        // R10 load beats tick
        wr(4'd2, 8'h10); wr(4'd3, 8'h00); wr(4'd4, 8'h00);
        step(1, 1, 0, 4'd5, 8'h00, 0, 0, "");
        rd(4'd2, "R10 load over tick");

        // R1 hold without tick
        idle(); idle();
        rd(4'd2, "R1 hold");

        // Random phase
        wr32(4'd10, 32'd40);
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [3:0] a;
            logic [7:0] d;
            op = int'($urandom_range(0, 9));
            a  = 4'($urandom_range(0, 13));
            d  = 8'($urandom);
            if ((a == 4'd8 || a == 4'd9 || a == 4'd12 || a == 4'd13 || a == 4'd4 || a == 4'd5)
                && $urandom_range(0, 3) != 0) d = 8'h00;
            if (op < 4)       step(1, 0, $urandom_range(0,1) == 1, a, d, 0, 0, "R1 random read");
            else if (op < 6)  step($urandom_range(0,1) == 1, 0, 1, a, d, 0, 0, "R9 random read");
            else if (op < 8)  step($urandom_range(0,1) == 1, 1, 0, a, d, 0, 0, "");
            else              step($urandom_range(0,1) == 1, 0, 1, 4'd1, d,
                                   $urandom_range(0,1) == 1, $urandom_range(0,1) == 1, "R6 random flags");
        end
        rd_all("R10 final readback");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule